// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block is the digital sequencer of a successive approximation converter. It drives an N-bit trial code to an external DAC and reads back one comparator bit. A high comparator bit means the analog input is at or above the level that the current trial code produces. The block resolves one bit per clock, starting at the most significant bit, and then publishes the finished code.

The finished code goes into an output buffer. That buffer stays unchanged through the whole of the next conversion, so a reader can take it at any time. Each decided bit also leaves the block at once on a serial output, most significant bit first, with its own qualifier. The DAC and the comparator sit outside the block.

The controller is a two-state machine:
- `ST_IDLE` waits for a start pulse.
- `ST_CONV` tests one bit per cycle.
- The *launch* transition (`ST_IDLE` to `ST_CONV`) is taken when `start_i` is high in `ST_IDLE`.
- The *finish* transition (`ST_CONV` to `ST_IDLE`) is taken in the cycle that decides bit 0.
- In every other case the state holds.

Top module: `sar_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `result_vld_o` and `ser_vld_o` are 0 and `result_o` is all zeros.
- R2: When `start_i` is high in a clock cycle where `busy_o` is low, `busy_o` is high in the next cycle. In that same cycle `trial_o` has only its most significant bit set.
- R3: Each bit under test is kept at 1 if `cmp_i` is high (input at or above the trial level) and cleared otherwise. After that the next lower bit is set to 1. For an ideal comparator (`cmp_i` = target >= `trial_o`), the published result equals the target code.
- R4: `busy_o` stays high for exactly N consecutive cycles per conversion, whatever the input.
- R5: A start pulse while `busy_o` is high has no effect. The running conversion still ends after N busy cycles with a single valid pulse, and no new conversion follows.
- R6: `result_o` and the one-cycle `result_vld_o` pulse update together, in the cycle after bit 0 is decided. In that cycle `busy_o` is low.
- R7: `result_o` keeps the previous result (all zeros before the first conversion) for every cycle of the next conversion.
- R8: In each busy cycle `ser_vld_o` is high and `ser_bit_o` carries the bit decided in that cycle. Over one conversion the bits arrive most significant first and together form the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request pulse |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| trial_o | output | N | Trial code to the DAC |
| result_o | output | N | Buffered result of the last finished conversion |
| result_vld_o | output | 1 | One-cycle pulse when `result_o` updates |
| ser_bit_o | output | 1 | Bit decided in the current cycle |
| ser_vld_o | output | 1 | Qualifier for `ser_bit_o` |
| busy_o | output | 1 | Conversion in progress |

## Verification
The hardest case to reach is a start request that lands in the middle of a running conversion. It must neither restart the bit walk nor queue a second conversion. The driver raises `start_i` on the third busy cycle of selected conversions. It then counts busy cycles and checks that exactly one result arrives and that the block goes idle after it. The all-zeros and all-ones targets, plus the codes just either side of mid-scale, make every bit decision go both ways.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_t;
endpackage

// File: rtl/sar_fsm.sv
module sar_fsm
    import sar_pkg::*;
#(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    output logic                  launch_o,
    output logic                  busy_o,
    output logic                  last_o,
    output logic [$clog2(N)-1:0]  idx_o
);
    localparam int IW = $clog2(N);
    localparam logic [IW-1:0] TOP_IDX = IW'(N - 1);

    sar_state_t state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_CONV;
                    idx_d   = TOP_IDX;
                end
            end
            ST_CONV: begin
                if (idx_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    idx_d = idx_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        busy_o   = (state_q == ST_CONV);
        launch_o = (state_q == ST_IDLE) && start_i;
        last_o   = busy_o && (idx_q == '0);
        idx_o    = idx_q;
    end
endmodule

// File: rtl/sar_trial.sv
module sar_trial #(
    parameter int N = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  launch_i,
    input  logic                  busy_i,
    input  logic [$clog2(N)-1:0]  idx_i,
    input  logic                  cmp_i,
    output logic [N-1:0]          trial_o
);
    localparam int IW = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_bit
        localparam logic [IW-1:0] OWN_IDX = IW'(g);
        logic set_next;
        if (g < N - 1) begin : g_below
            localparam logic [IW-1:0] UP_IDX = IW'(g + 1);
            assign set_next = (idx_i == UP_IDX);
        end else begin : g_top
            assign set_next = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                trial_o[g] <= 1'b0;
            end else if (launch_i) begin
                trial_o[g] <= (g == N - 1);
            end else if (busy_i) begin
                if (idx_i == OWN_IDX) begin
                    trial_o[g] <= cmp_i;
                end else if (set_next) begin
                    trial_o[g] <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sar_outbuf.sv
module sar_outbuf #(
    parameter int N = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          last_i,
    input  logic [N-1:1]  upper_i,
    input  logic          cmp_i,
    output logic [N-1:0]  result_o,
    output logic          vld_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= last_i;
            if (last_i) begin
                result_o <= {upper_i, cmp_i};
            end
        end
    end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
    parameter int N = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cmp_i,
    output logic [N-1:0]  trial_o,
    output logic [N-1:0]  result_o,
    output logic          result_vld_o,
    output logic          ser_bit_o,
    output logic          ser_vld_o,
    output logic          busy_o
);
    localparam int IW = $clog2(N);

    logic          launch;
    logic          last;
    logic [IW-1:0] idx;

    sar_fsm #(.N(N)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .launch_o (launch),
        .busy_o   (busy_o),
        .last_o   (last),
        .idx_o    (idx)
    );

    sar_trial #(.N(N)) u_trial (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .busy_i   (busy_o),
        .idx_i    (idx),
        .cmp_i    (cmp_i),
        .trial_o  (trial_o)
    );

    sar_outbuf #(.N(N)) u_outbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .last_i   (last),
        .upper_i  (trial_o[N-1:1]),
        .cmp_i    (cmp_i),
        .result_o (result_o),
        .vld_o    (result_vld_o)
    );

    assign ser_vld_o = busy_o;
    assign ser_bit_o = busy_o & cmp_i;
endmodule

// File: rtl/sar_chk.sv
module sar_chk #(
    parameter int N = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [N-1:0]  trial_o,
    input logic [N-1:0]  result_o,
    input logic          result_vld_o,
    input logic          ser_vld_o,
    input logic          busy_o
);
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    int run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 0;
        else if (busy_o) run_q <= run_q + 1;
        else run_q <= 0;
    end

    // R4
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= N);

    // R4
    busy_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (run_q == N));

    // R2
    launch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (trial_o == MSB_ONLY));

    // R2
    start_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    // R6
    vld_after_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_vld_o |-> ($fell(busy_o) && !$stable(result_o) || $fell(busy_o)));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(result_o));

    // R6
    result_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_o) |-> result_vld_o);

    // R8
    ser_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ser_vld_o |-> busy_o);
endmodule

bind sar_ctrl sar_chk #(.N(N)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .trial_o      (trial_o),
    .result_o     (result_o),
    .result_vld_o (result_vld_o),
    .ser_vld_o    (ser_vld_o),
    .busy_o       (busy_o)
);

// File: tb/sim_sar_ctrl.sv
`timescale 1ns/1ps
module sim_sar_ctrl;
    localparam int N = 8;
    localparam logic [N-1:0] MSB_ONLY = {1'b1, {(N-1){1'b0}}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [N-1:0] tgt = '0;
    logic cmp;
    logic [N-1:0] trial, result;
    logic result_vld, ser_bit, ser_vld, busy;

    int vectors = 0;
    int miscomp = 0;
    bit done = 1'b0;
    logic [N-1:0] exp_q[$];
    logic [N-1:0] prev_res = '0;
    logic [N-1:0] ser_acc = '0;

    always #2.5 clk = ~clk;

    // ideal DAC and comparator: high when the input is at or above the trial level
    assign cmp = (tgt >= trial);

    sar_ctrl #(.N(N)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .cmp_i        (cmp),
        .trial_o      (trial),
        .result_o     (result),
        .result_vld_o (result_vld),
        .ser_bit_o    (ser_bit),
        .ser_vld_o    (ser_vld),
        .busy_o       (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        vectors++;
        if (!ok) begin
            miscomp++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ser_vld) ser_acc = {ser_acc[N-2:0], ser_bit};
            if (busy) chk(result == prev_res, "R7 result held", result, prev_res);
            if (result_vld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected valid", result, '0);
                end else begin
                    logic [N-1:0] e;
                    e = exp_q.pop_front();
                    chk(result == e, "R3 result", result, e);
                    chk(ser_acc == e, "R8 serial bits", ser_acc, e);
                    chk(!busy, "R6 busy low with valid", {{(N-1){1'b0}}, busy}, '0);
                    prev_res = e;
                end
            end
        end
    end

    // driver
    task automatic convert(input logic [N-1:0] t, input bit poke);
        @(negedge clk);
        while (busy) @(negedge clk);
        tgt = t;
        exp_q.push_back(t);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 busy after start", {{(N-1){1'b0}}, busy}, 1);
        chk(trial == MSB_ONLY, "R2 first trial code", trial, MSB_ONLY);
        begin
            int cnt;
            cnt = 0;
            while (busy) begin
                cnt++;
                start = (poke && cnt == 3);
                @(negedge clk);
            end
            start = 1'b0;
            chk(cnt == N, "R4 busy length", N'(cnt), N'(N));
        end
        chk(result_vld, "R6 valid after bit 0", {{(N-1){1'b0}}, result_vld}, 1);
        @(negedge clk);
        chk(!result_vld, "R6 valid one cycle", {{(N-1){1'b0}}, result_vld}, 0);
        if (poke) chk(!busy, "R5 ignored start", {{(N-1){1'b0}}, busy}, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        miscomp++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 during reset
        chk(!busy && !result_vld && !ser_vld && result == '0, "R1 in reset",
            {busy, result_vld, ser_vld, result[N-4:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !result_vld && !ser_vld && result == '0, "R1 after reset",
            {busy, result_vld, ser_vld, result[N-4:0]}, '0);

        convert(8'h00, 1'b0);
        convert(8'hFF, 1'b0);
        convert(8'h80, 1'b1);
        convert(8'h7F, 1'b0);
        convert(8'h55, 1'b1);
        convert(8'hAA, 1'b0);
        convert(8'h01, 1'b0);
        convert(8'hFE, 1'b1);
        for (int i = 0; i < 20; i++) begin
            convert(N'((i * 37 + 11) % 256), (i % 3) == 0);
        end
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R6 all results delivered", N'(exp_q.size()), '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule